// File: doc/BRIEF.md
# Dual-Mode Convolutional Byte De-interleaver

This block undoes a byte-wise convolutional interleave on a byte stream that arrives one byte per valid cycle. A rotating commutator sends each accepted byte to one of several branches, and each branch delays its bytes by its own fixed number of visits. Branch 0 has the longest delay and the last branch has none. After the bytes have passed the complementary delays, they leave in their original order. All branch delay lines share a single RAM array. Each branch owns a contiguous circular region in that array and keeps a private pointer, which advances only when the commutator selects that branch.

Two formats are supported and a mode input selects between them. Mode 0 uses 12 branches with a unit delay of 17 bytes. Mode 1 uses 13 branches with a unit delay of 12 bytes. The two formats lay out the shared RAM differently and are otherwise handled the same way. A block-start flag on an input byte forces that byte into branch 0. The flag is stored next to the byte, so the output start flag marks the same byte when it comes out. Output is held back after reset and after any change of mode until every delay line holds real data.

Top module: `cdi_top`

## Requirements
- R1: With `mode_i`=0 there are 12 branches. A byte accepted into branch j (0..11) comes out, one cycle after a later accepted byte that is also routed to branch j, on the 17×(11−j)-th such later visit.
- R2: With `mode_i`=1 there are 13 branches. A byte accepted into branch j (0..12) comes out on the 12×(12−j)-th later visit to branch j, one cycle after that visit.
- R3: When no block-start flag is present, successive accepted bytes go to branches 0,1,…,last,0,… in order. A cycle with `in_vld_i`=0 leaves the commutator where it was and produces `out_vld_o`=0 in the next cycle.
- R4: A byte with `in_sop_i`=1 is always routed to branch 0, and the byte after it goes to branch 1. The contents and pointers of all branches are kept.
- R5: `out_sop_o` is 1 exactly when the output byte is one that entered with `in_sop_i`=1. It is never 1 while `out_vld_o` is 0.
- R6: Each accepted byte produces its output result in the next cycle. A byte routed to the last branch is output unchanged in the next cycle.
- R7: After reset, `out_vld_o` stays 0 until every branch with a nonzero delay has been visited as many times as its delay. The first visit after that point gives valid output.
- R8: In a cycle where `mode_i` differs from its value in the previous cycle (or from 0 for the first cycle after reset), the input byte is dropped. The commutator and all branch pointers restart at 0, and output is suppressed again as in R7 under the new mode.
- R9: During reset and whenever `out_vld_o` is 0, `out_sop_o` and `out_data_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Format select: 0 = 12 branches × 17, 1 = 13 branches × 12 |
| in_vld_i | input | 1 | Input byte valid |
| in_sop_i | input | 1 | Input byte is a block start (forces branch 0) |
| in_data_i | input | DW (8) | Input byte |
| out_vld_o | output | 1 | Output byte valid |
| out_sop_o | output | 1 | Output byte is a block start |
| out_data_o | output | DW (8) | De-interleaved byte |

## Verification
If one branch pointer goes wrong, the ports show it as a wrong byte on every later visit to that branch, once that branch has been filled. The bench compares every valid output byte, so the error shows up within one full commutator rotation after the fill. If a region base or length is wrong, the result is a byte from a neighbouring branch or a byte one visit off. Both show up at the first valid output from the affected branch. A wrong full-flag or mode-change reset moves the cycle in which `out_vld_o` first rises, and a commutator that does not respect a block-start flag moves `out_sop_o` to a different byte. Both can be seen as soon as the stream restarts after the fill.

// File: rtl/cdi_pkg.sv
package cdi_pkg;

    // Number of RAM slots owned by branch j of an n-branch interleave.
    function automatic int unsigned br_len(int unsigned unit, int unsigned n, int unsigned j);
        return unit * (n - 1 - j);
    endfunction

    // First RAM slot of branch j: the summed lengths of branches 0..j-1.
    function automatic int unsigned br_base(int unsigned unit, int unsigned n, int unsigned j);
        return unit * (j * (n - 1) - (j * (j - 1)) / 2);
    endfunction

    // RAM slots needed by a whole n-branch interleave.
    function automatic int unsigned total_len(int unsigned unit, int unsigned n);
        return unit * n * (n - 1) / 2;
    endfunction

endpackage

// File: rtl/cdi_ram.sv
module cdi_ram #(
    parameter int DEPTH = 1122,
    parameter int AW    = 11,
    parameter int WW    = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [WW-1:0] wdata_i,
    output logic [WW-1:0] rdata_o
);

    logic [WW-1:0] mem_q [DEPTH];

    // Write and read share one address: the old word leaves as the new one lands.
    always_ff @(posedge clk) begin
        if (en_i) mem_q[addr_i] <= wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rdata_o <= '0;
        else if (en_i) rdata_o <= mem_q[addr_i];
    end

endmodule

// File: rtl/cdi_addr.sv
module cdi_addr
    import cdi_pkg::*;
#(
    parameter int NA   = 12,
    parameter int UA   = 17,
    parameter int NB   = 13,
    parameter int UB   = 12,
    parameter int NMAX = 13,
    parameter int IW   = 4,
    parameter int AW   = 11,
    parameter int PW   = 8
) (
    input  logic            mode_i,
    input  logic [IW-1:0]   br_i,
    output logic [AW-1:0]   base_o,
    output logic [PW-1:0]   len_o,
    output logic [IW-1:0]   last_o,
    output logic [NMAX-1:0] deep_o
);

    logic [AW-1:0] base_a [NMAX];
    logic [AW-1:0] base_b [NMAX];
    logic [PW-1:0] len_a  [NMAX];
    logic [PW-1:0] len_b  [NMAX];

    for (genvar g = 0; g < NMAX; g++) begin : g_tab
        if (g < NA) begin : g_a
            assign base_a[g] = AW'(br_base(UA, NA, g));
            assign len_a[g]  = PW'(br_len(UA, NA, g));
        end else begin : g_na
            assign base_a[g] = '0;
            assign len_a[g]  = '0;
        end
        if (g < NB) begin : g_b
            assign base_b[g] = AW'(br_base(UB, NB, g));
            assign len_b[g]  = PW'(br_len(UB, NB, g));
        end else begin : g_nb
            assign base_b[g] = '0;
            assign len_b[g]  = '0;
        end
        // Branches with a real delay line: every one but the last of the mode.
        assign deep_o[g] = mode_i ? (g < NB - 1) : (g < NA - 1);
    end

    always_comb begin
        base_o = mode_i ? base_b[br_i] : base_a[br_i];
        len_o  = mode_i ? len_b[br_i]  : len_a[br_i];
        last_o = mode_i ? IW'(NB - 1)  : IW'(NA - 1);
    end

endmodule

// File: rtl/cdi_top.sv
module cdi_top
    import cdi_pkg::*;
#(
    parameter int DW = 8,
    parameter int NA = 12,
    parameter int UA = 17,
    parameter int NB = 13,
    parameter int UB = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_i,
    input  logic          in_vld_i,
    input  logic          in_sop_i,
    input  logic [DW-1:0] in_data_i,
    output logic          out_vld_o,
    output logic          out_sop_o,
    output logic [DW-1:0] out_data_o
);

    localparam int NMAX  = (NA > NB) ? NA : NB;
    localparam int DEPA  = total_len(UA, NA);
    localparam int DEPB  = total_len(UB, NB);
    localparam int DEPTH = (DEPA > DEPB) ? DEPA : DEPB;
    localparam int AW    = $clog2(DEPTH);
    localparam int LMAXA = UA * (NA - 1);
    localparam int LMAXB = UB * (NB - 1);
    localparam int LMAX  = (LMAXA > LMAXB) ? LMAXA : LMAXB;
    localparam int PW    = $clog2(LMAX + 1);
    localparam int IW    = $clog2(NMAX);
    localparam int WW    = DW + 1;

    typedef struct packed {
        logic                     mode;
        logic [IW-1:0]            idx;
        logic [NMAX-1:0][PW-1:0]  ptr;
        logic [NMAX-1:0]          full;
        logic                     vld;
        logic                     byp;
        logic [WW-1:0]            byp_w;
    } st_t;

    st_t st_d, st_q;

    logic [IW-1:0]   br;
    logic [AW-1:0]   base;
    logic [PW-1:0]   len;
    logic [IW-1:0]   last;
    logic [NMAX-1:0] deep;
    logic            mem_en;
    logic [AW-1:0]   mem_addr;
    logic [WW-1:0]   mem_rd;
    logic            chg;
    logic            all_full;

    // Observation points for the bound checker.
    logic [7:0] dbg_idx;
    logic [7:0] dbg_last;
    logic       dbg_mode;

    // A block start always lands in branch 0.
    assign br = in_sop_i ? '0 : st_q.idx;

    cdi_addr #(
        .NA(NA), .UA(UA), .NB(NB), .UB(UB),
        .NMAX(NMAX), .IW(IW), .AW(AW), .PW(PW)
    ) u_addr (
        .mode_i (mode_i),
        .br_i   (br),
        .base_o (base),
        .len_o  (len),
        .last_o (last),
        .deep_o (deep)
    );

    always_comb begin
        st_d       = st_q;
        st_d.mode  = mode_i;
        st_d.vld   = 1'b0;
        st_d.byp   = 1'b0;
        st_d.byp_w = {in_sop_i, in_data_i};
        mem_en     = 1'b0;
        mem_addr   = base + AW'(st_q.ptr[br]);
        chg        = (mode_i != st_q.mode);
        all_full   = &(st_q.full | ~deep);

        if (chg) begin
            st_d.idx  = '0;
            st_d.ptr  = '0;
            st_d.full = '0;
        end else if (in_vld_i) begin
            st_d.idx = (br == last) ? '0 : br + IW'(1);
            st_d.vld = all_full;
            if (len == '0) begin
                st_d.byp = 1'b1;
            end else begin
                mem_en = 1'b1;
                if (st_q.ptr[br] == len - PW'(1)) begin
                    st_d.ptr[br]  = '0;
                    st_d.full[br] = 1'b1;
                end else begin
                    st_d.ptr[br] = st_q.ptr[br] + PW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    cdi_ram #(.DEPTH(DEPTH), .AW(AW), .WW(WW)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (mem_en),
        .addr_i  (mem_addr),
        .wdata_i ({in_sop_i, in_data_i}),
        .rdata_o (mem_rd)
    );

    logic [WW-1:0] out_w;
    assign out_w      = st_q.byp ? st_q.byp_w : mem_rd;
    assign out_vld_o  = st_q.vld;
    assign out_sop_o  = st_q.vld & out_w[DW];
    assign out_data_o = st_q.vld ? out_w[DW-1:0] : '0;

    assign dbg_idx  = 8'(st_q.idx);
    assign dbg_last = 8'(last);
    assign dbg_mode = st_q.mode;

endmodule

// File: rtl/cdi_chk.sv
module cdi_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_i,
    input logic       in_vld_i,
    input logic       in_sop_i,
    input logic       out_vld_o,
    input logic       out_sop_o,
    input logic [7:0] dbg_idx,
    input logic [7:0] dbg_last,
    input logic       dbg_mode
);

    // R3: output only follows an accepted byte
    p_out_follows_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld_o |-> $past(in_vld_i));

    // R3: commutator index stays inside the active branch range
    p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_idx <= dbg_last);

    // R3: an idle cycle neither advances the commutator nor emits output
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_vld_i && mode_i == dbg_mode) |=> ($stable(dbg_idx) && !out_vld_o));

    // R4: a block start uses branch 0, so the next byte goes to branch 1
    p_sync_branch0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld_i && in_sop_i && mode_i == dbg_mode) |=> (dbg_idx == 8'd1));

    // R5: start flag only on valid output
    p_sop_needs_vld_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_sop_o |-> out_vld_o);

    // R8: a mode change drops the byte and restarts the commutator
    p_mode_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != dbg_mode) |=> (!out_vld_o && dbg_idx == 8'd0));

endmodule

bind cdi_top cdi_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_i),
    .in_vld_i  (in_vld_i),
    .in_sop_i  (in_sop_i),
    .out_vld_o (out_vld_o),
    .out_sop_o (out_sop_o),
    .dbg_idx   (dbg_idx),
    .dbg_last  (dbg_last),
    .dbg_mode  (dbg_mode)
);

// File: tb/tb_cdi_top.sv
module tb_cdi_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_i = 1'b0;
    logic       in_vld_i = 1'b0;
    logic       in_sop_i = 1'b0;
    logic [7:0] in_data_i = '0;
    logic       out_vld_o;
    logic       out_sop_o;
    logic [7:0] out_data_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    cdi_top dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .in_vld_i(in_vld_i), .in_sop_i(in_sop_i), .in_data_i(in_data_i),
        .out_vld_o(out_vld_o), .out_sop_o(out_sop_o), .out_data_o(out_data_o)
    );

    // Reference model: one queue per branch.
    logic [8:0] bq [13][$];
    int         m_br   = 0;
    bit         m_mode = 0;
    bit         exp_v  = 0;
    bit         exp_s  = 0;
    logic [7:0] exp_d  = '0;
    string      exp_tag = "R9";

    function automatic int nbr(bit m);
        return m ? 13 : 12;
    endfunction

    function automatic int blen(bit m, int j);
        return m ? 12 * (12 - j) : 17 * (11 - j);
    endfunction

    task automatic model(bit m, bit v, bit s, logic [7:0] d, string ptag);
        bit allf;
        int b;
        logic [8:0] w;
        exp_v = 0; exp_s = 0; exp_d = '0;
        if (m != m_mode) begin
            for (int j = 0; j < 13; j++) bq[j].delete();
            m_br = 0; m_mode = m; exp_tag = "R8";
            return;
        end
        if (!v) begin exp_tag = "R3"; return; end
        allf = 1;
        for (int j = 0; j < nbr(m); j++) if (bq[j].size() != blen(m, j)) allf = 0;
        b = s ? 0 : m_br;
        m_br = (b == nbr(m) - 1) ? 0 : b + 1;
        bq[b].push_back({s, d});
        w = '0;
        if (bq[b].size() > blen(m, b)) w = bq[b].pop_front();
        exp_v = allf;
        if (allf) begin exp_s = w[8]; exp_d = w[7:0]; end
        exp_tag = !allf ? "R7" : (b == nbr(m) - 1) ? "R6" : ptag;
    endtask

    task automatic compare();
        checks++;
        if (out_vld_o !== exp_v) begin
            fails++;
            $display("FAIL %s valid: got %0b expected %0b", exp_tag, out_vld_o, exp_v);
        end
        checks++;
        if (out_data_o !== exp_d) begin
            fails++;
            $display("FAIL %s data: got %02h expected %02h", exp_tag, out_data_o, exp_d);
        end
        checks++;
        if (out_sop_o !== exp_s) begin
            fails++;
            $display("FAIL R5 start flag (%s): got %0b expected %0b", exp_tag, out_sop_o, exp_s);
        end
    endtask

    // One cycle: check the result of the previous input, then apply the next.
    task automatic step(bit m, bit v, bit s, logic [7:0] d, string ptag);
        @(negedge clk);
        compare();
        model(m, v, s, d, ptag);
        mode_i = m; in_vld_i = v; in_sop_i = s; in_data_i = d;
    endtask

    task automatic phase(bit m, int ncyc, int period, bit irregular, string ptag);
        int cnt = 0;
        for (int i = 0; i < ncyc; i++) begin
            bit v, s;
            v = ($urandom % 5) != 0;
            s = 0;
            if (v) begin
                s = (cnt % period) == 0;
                if (irregular && ($urandom % 40) == 0) s = 1;
                cnt++;
            end
            step(m, v, s, 8'($urandom), ptag);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R9: outputs clear straight out of reset
        checks++;
        if (out_vld_o !== 1'b0 || out_sop_o !== 1'b0 || out_data_o !== 8'h00) begin
            fails++;
            $display("FAIL R9 reset: got %0b/%0b/%02h expected 0/0/00",
                     out_vld_o, out_sop_o, out_data_o);
        end
        exp_tag = "R9";
        // R1: 12-branch format, regular blocks of 204
        phase(1'b0, 7000, 204, 1'b0, "R1");
        // R3: idle stretch keeps the commutator still
        for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 1'b0, 8'h00, "R3");
        phase(1'b0, 1500, 204, 1'b0, "R1");
        // R4: block starts arriving mid-rotation
        phase(1'b0, 3000, 204, 1'b1, "R4");
        // R8: switch to the 13-branch format with a valid byte on the change cycle
        step(1'b1, 1'b1, 1'b1, 8'hA5, "R8");
        // R2: 13-branch format, regular blocks of 147
        phase(1'b1, 7000, 147, 1'b0, "R2");
        phase(1'b1, 2000, 147, 1'b1, "R4");
        // R8: back to the 12-branch format
        step(1'b0, 1'b1, 1'b0, 8'h5A, "R8");
        phase(1'b0, 6000, 204, 1'b0, "R1");
        step(1'b0, 1'b0, 1'b0, 8'h00, "R3");
        @(negedge clk);
        compare();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            $display("FAIL R3 watchdog: got no completion expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule